// File: doc/BRIEF.md
# ADC Result Offset Correction and Output Formatter

This block sits behind the pipelined core of a 14-bit data converter. It receives raw conversion codes in straight-binary form, each with a valid strobe and an over-range flag. When correction is enabled, it adds a signed offset to each code. It then saturates the sum to the 14-bit signed range and presents the result either as straight binary or as two's complement. The over-range flag travels through the same stages as its data, so the flag and the word always leave the block together.

The analog core's latency is modelled only as a register delay line of `LATENCY` stages in total, with a default of 10. The offset-enable and format settings are captured together with each sample. A host can therefore change them at any time without disturbing samples that are already in flight. Cycles without a sample travel through the block as bubbles, and during a bubble the output word and flag keep their last values.

Top module: `adc_post_top`

## Requirements
- R1: While `rstN` is low, and after reset until the first sample emerges, `resValid`, `resCode` and `resOver` are all 0.
- R2: A sample presented with `rawValid` high at rising edge e appears on the outputs, with `resValid` high, right after rising edge e+LATENCY-1. With the default of 10 this is ten register stages counting the capturing edge.
- R3: With correction disabled (`offsetDis`=1) and straight-binary output (`fmtTwos`=0), `resCode` equals `rawCode`. Raw code 0 is negative full scale, 8192 is zero and 16383 is positive full scale minus one LSB.
- R4: With `fmtTwos`=1 the result is in two's complement, which is the straight-binary code with bit 13 inverted. Raw 8192 gives 0, raw 0 gives 0x2000 (-8192) and raw 16383 gives 0x1FFF (+8191).
- R5: With `offsetDis`=0, the result equals (rawCode - 8192) + offsetVal as a signed value. `offsetVal` is 8-bit two's complement, covering -128 to +127. The result is then encoded in the selected format.
- R6: The corrected value saturates at +8191 and -8192 instead of wrapping. In straight binary these limits are 16383 and 0.
- R7: A result that saturated is reported with `resOver`=1.
- R8: A sample presented with `rawOver`=1 leaves the block with `resOver`=1, on the same output cycle as its data.
- R9: `fmtTwos`, `offsetDis` and `offsetVal` are taken at the edge that captures a sample. Changing them on a later cycle does not alter that sample's result.
- R10: On a cycle whose output stage holds no sample, `resValid` is 0, and `resCode` and `resOver` keep their previous values.
- R11: While `offsetDis`=1, any value on `offsetVal` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| rawValid | input | 1 | A raw sample is present this cycle |
| rawCode | input | 14 | Raw conversion code, straight binary |
| rawOver | input | 1 | Analog input exceeded the reference span |
| offsetVal | input | 8 | Signed offset correction in LSB |
| offsetDis | input | 1 | 1 turns offset correction off |
| fmtTwos | input | 1 | 0 selects straight binary, 1 selects two's complement |
| resValid | output | 1 | Output word holds a new result |
| resCode | output | 14 | Corrected and formatted result |
| resOver | output | 1 | Over-range, from the input flag or from saturation |

## Verification
The hardest state to reach is a stage that holds a sample whose captured settings differ from the values now on the setting pins. This state only exists when the format and offset controls change while earlier samples are still inside the delay line. The stimulus therefore redraws `fmtTwos`, `offsetDis` and `offsetVal` on every cycle, including bubble cycles, and the bench computes each expected value from the settings present at the sample's capture edge. Directed samples placed near both full-scale ends with extreme offsets push the sum past either limit, which covers saturation and its over-range flag.

// File: rtl/adc_post_pkg.sv
package adc_post_pkg;
  parameter int CODE_W = 14;
  parameter int OFS_W  = 8;

  // strobes from the control half to the datapath, one set per captured sample
  typedef struct packed {
    logic valid;
    logic addOfs;
    logic twos;
  } stageCtl_t;

  // one word moving through the delay line
  typedef struct packed {
    logic              valid;
    logic              over;
    logic [CODE_W-1:0] code;
  } resWord_t;
endpackage

// File: rtl/adc_post_ctrl.sv
module adc_post_ctrl
  import adc_post_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      rawValid,
  input  logic      offsetDis,
  input  logic      fmtTwos,
  output stageCtl_t stb
);
  // settings are latched with the sample so that later changes leave it alone
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stb <= '0;
    end else begin
      stb.valid <= rawValid;
      if (rawValid) begin
        stb.addOfs <= ~offsetDis;
        stb.twos   <= fmtTwos;
      end
    end
  end
endmodule

// File: rtl/adc_post_dp.sv
module adc_post_dp
  import adc_post_pkg::*;
#(
  parameter int LATENCY = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  stageCtl_t         stb,
  input  logic              rawValid,
  input  logic [CODE_W-1:0] rawCode,
  input  logic              rawOver,
  input  logic [OFS_W-1:0]  offsetVal,
  output logic              resValid,
  output logic [CODE_W-1:0] resCode,
  output logic              resOver
);
  localparam int SUM_W = CODE_W + 1;
  localparam int NMID  = LATENCY - 3;  // stages between compute and output

  logic [CODE_W-1:0] capCode;
  logic              capOver;
  logic [OFS_W-1:0]  capOfs;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capCode <= '0;
      capOver <= 1'b0;
      capOfs  <= '0;
    end else if (rawValid) begin
      capCode <= rawCode;
      capOver <= rawOver;
      capOfs  <= offsetVal;
    end
  end

  // offset add in signed form, saturate, then encode
  logic [CODE_W-1:0]        centered;
  logic signed [SUM_W-1:0]  ofsExt;
  logic signed [SUM_W-1:0]  sumS;
  logic                     satHit;
  logic [CODE_W-1:0]        signedRes;
  logic [CODE_W-1:0]        fmtRes;

  always_comb begin
    centered = {~capCode[CODE_W-1], capCode[CODE_W-2:0]};
    ofsExt   = stb.addOfs ? $signed({{(SUM_W-OFS_W){capOfs[OFS_W-1]}}, capOfs}) : '0;
    sumS     = $signed({centered[CODE_W-1], centered}) + ofsExt;
    satHit   = sumS[SUM_W-1] ^ sumS[SUM_W-2];
    if (!satHit)
      signedRes = sumS[CODE_W-1:0];
    else if (sumS[SUM_W-1])
      signedRes = {1'b1, {(CODE_W-1){1'b0}}};
    else
      signedRes = {1'b0, {(CODE_W-1){1'b1}}};
    fmtRes = stb.twos ? signedRes : {~signedRes[CODE_W-1], signedRes[CODE_W-2:0]};
  end

  resWord_t cmpWord;
  resWord_t tailWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpWord <= '0;
    end else begin
      cmpWord.valid <= stb.valid;
      cmpWord.over  <= stb.valid & (capOver | satHit);
      cmpWord.code  <= fmtRes;
    end
  end

  generate
    if (NMID == 0) begin : g_noMid
      assign tailWord = cmpWord;
    end else begin : g_mid
      resWord_t midWord [NMID];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int k = 0; k < NMID; k++) midWord[k] <= '0;
        end else begin
          midWord[0] <= cmpWord;
          for (int k = 1; k < NMID; k++) midWord[k] <= midWord[k-1];
        end
      end
      assign tailWord = midWord[NMID-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resCode  <= '0;
      resOver  <= 1'b0;
    end else begin
      resValid <= tailWord.valid;
      if (tailWord.valid) begin
        resCode <= tailWord.code;
        resOver <= tailWord.over;
      end
    end
  end
endmodule

// File: rtl/adc_post_top.sv
module adc_post_top
  import adc_post_pkg::*;
#(
  parameter int LATENCY = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rawValid,
  input  logic [13:0] rawCode,
  input  logic        rawOver,
  input  logic [7:0]  offsetVal,
  input  logic        offsetDis,
  input  logic        fmtTwos,
  output logic        resValid,
  output logic [13:0] resCode,
  output logic        resOver
);
  stageCtl_t stb;

  adc_post_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .rawValid  (rawValid),
    .offsetDis (offsetDis),
    .fmtTwos   (fmtTwos),
    .stb       (stb)
  );

  adc_post_dp #(.LATENCY(LATENCY)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .rawValid  (rawValid),
    .rawCode   (rawCode),
    .rawOver   (rawOver),
    .offsetVal (offsetVal),
    .resValid  (resValid),
    .resCode   (resCode),
    .resOver   (resOver)
  );
endmodule

// File: rtl/adc_post_chk.sv
module adc_post_chk
  import adc_post_pkg::*;
#(
  parameter int LATENCY = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              rawValid,
  input logic [CODE_W-1:0] rawCode,
  input logic              rawOver,
  input logic              offsetDis,
  input logic              fmtTwos,
  input stageCtl_t         stb,
  input logic              resValid,
  input logic [CODE_W-1:0] resCode,
  input logic              resOver
);
  logic [LATENCY-1:0] vHist, oHist, pHist;
  logic [CODE_W-1:0]  cHist [LATENCY];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vHist <= '0;
      oHist <= '0;
      pHist <= '0;
      for (int k = 0; k < LATENCY; k++) cHist[k] <= '0;
    end else begin
      vHist <= {vHist[LATENCY-2:0], rawValid};
      oHist <= {oHist[LATENCY-2:0], rawValid & rawOver};
      pHist <= {pHist[LATENCY-2:0], rawValid & offsetDis & ~fmtTwos};
      cHist[0] <= rawCode;
      for (int k = 1; k < LATENCY; k++) cHist[k] <= cHist[k-1];
    end
  end

  a_r2_latency: assert property (@(posedge clk) disable iff (!rstN)
    resValid == vHist[LATENCY-1]);

  a_r8_over_aligned: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && oHist[LATENCY-1]) |-> resOver);

  a_r3_plain_pass: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && pHist[LATENCY-1] && !oHist[LATENCY-1]) |-> (resCode == cHist[LATENCY-1]));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> ($stable(resCode) && $stable(resOver)));

  a_r9_settings_latched: assert property (@(posedge clk) disable iff (!rstN)
    stb.valid |-> (stb.twos == $past(fmtTwos) && stb.addOfs == !$past(offsetDis)));
endmodule

bind adc_post_top adc_post_chk #(.LATENCY(LATENCY)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .rawValid  (rawValid),
  .rawCode   (rawCode),
  .rawOver   (rawOver),
  .offsetDis (offsetDis),
  .fmtTwos   (fmtTwos),
  .stb       (stb),
  .resValid  (resValid),
  .resCode   (resCode),
  .resOver   (resOver)
);

// File: tb/adc_post_top_tb.sv
module adc_post_top_tb;
  localparam int LAT  = 10;
  localparam int RING = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rawValid = 1'b0;
  logic [13:0] rawCode = '0;
  logic        rawOver = 1'b0;
  logic [7:0]  offsetVal = '0;
  logic        offsetDis = 1'b1;
  logic        fmtTwos = 1'b0;
  logic        resValid;
  logic [13:0] resCode;
  logic        resOver;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  logic        expV [RING];
  logic [13:0] expC [RING];
  logic        expO [RING];
  string       expT [RING];
  logic [13:0] heldC = '0;
  logic        heldO = 1'b0;

  always #5 clk = ~clk;

  adc_post_top #(.LATENCY(LAT)) u_dut (
    .clk(clk), .rstN(rstN), .rawValid(rawValid), .rawCode(rawCode),
    .rawOver(rawOver), .offsetVal(offsetVal), .offsetDis(offsetDis),
    .fmtTwos(fmtTwos), .resValid(resValid), .resCode(resCode), .resOver(resOver)
  );

  // reference: returns {over, code}
  function automatic logic [14:0] model(input logic [13:0] code, input logic ov,
                                        input logic [7:0] ofs, input logic dis,
                                        input logic twos);
    int s;
    logic sat;
    logic [13:0] r;
    s = int'(code) - 8192;
    if (!dis) s = s + int'($signed(ofs));
    sat = 1'b0;
    if (s > 8191)  begin s = 8191;  sat = 1'b1; end
    if (s < -8192) begin s = -8192; sat = 1'b1; end
    r = twos ? 14'(s) : 14'(s + 8192);
    return {ov | sat, r};
  endfunction

  task automatic step(input logic v, input logic [13:0] code, input logic ov,
                      input logic [7:0] ofs, input logic dis, input logic twos,
                      input string tag);
    int slot;
    logic [14:0] m;
    @(negedge clk);
    cyc++;
    slot = cyc % RING;
    if (expT[slot] != "") begin
      logic eV; logic [13:0] eC; logic eO;
      eV = expV[slot];
      if (eV) begin heldC = expC[slot]; heldO = expO[slot]; end
      eC = heldC; eO = heldO;
      checks++;
      if (resValid !== eV || resCode !== eC || resOver !== eO) begin
        failures++;
        $display("FAIL %s cyc=%0d actual v=%0b code=%0d ov=%0b expected v=%0b code=%0d ov=%0b",
                 expT[slot], cyc, resValid, resCode, resOver, eV, eC, eO);
      end
      expT[slot] = "";
    end
    rawValid = v; rawCode = code; rawOver = ov;
    offsetVal = ofs; offsetDis = dis; fmtTwos = twos;
    slot = (cyc + LAT) % RING;
    m = model(code, ov, ofs, dis, twos);
    expV[slot] = v;
    expC[slot] = m[13:0];
    expO[slot] = m[14];
    expT[slot] = v ? tag : "R10";
  endtask

  initial begin
    for (int k = 0; k < RING; k++) begin
      expT[k] = ""; expV[k] = 0; expC[k] = '0; expO[k] = 0;
    end
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    // R1: outputs cleared during reset
    checks++;
    if (resValid !== 1'b0 || resCode !== 14'd0 || resOver !== 1'b0) begin
      failures++;
      $display("FAIL R1 actual v=%0b code=%0d ov=%0b expected 0 0 0", resValid, resCode, resOver);
    end
    rstN = 1'b1;
    cyc = 0;

    // directed corner cases
    step(1, 14'd8192,  0, 8'd77,  1, 0, "R3");   // mid scale, offset ignored
    step(1, 14'd16383, 0, 8'd0,   1, 0, "R3");
    step(1, 14'd0,     0, 8'd0,   1, 1, "R4");   // -8192
    step(1, 14'd16383, 0, 8'd0,   1, 1, "R4");   // +8191
    step(1, 14'd8192,  0, 8'd0,   1, 1, "R4");   // 0
    step(1, 14'd8192,  0, 8'd5,   0, 0, "R5");   // 8197
    step(1, 14'd100,   0, 8'h80,  0, 1, "R5");   // -128 offset
    step(1, 14'd16380, 0, 8'd127, 0, 0, "R6");   // clamp high, R7 flag
    step(1, 14'd3,     0, 8'h80,  0, 1, "R7");   // clamp low in two's
    step(1, 14'd5000,  1, 8'd10,  0, 0, "R8");
    step(1, 14'd1234,  0, 8'h9C,  1, 0, "R11");  // offset -100 ignored
    step(1, 14'd4000,  0, 8'd50,  0, 1, "R9");
    step(0, 14'd0,     0, 8'h81,  1, 0, "R9");   // settings change after capture
    step(0, 14'd0,     0, 8'd0,   0, 0, "R10");
    step(1, 14'd9000,  0, 8'd0,   1, 0, "R2");
    repeat (LAT + 2) step(0, 14'd0, 0, 8'd0, 1, 0, "R10");

    // constrained random with boundary-biased codes
    for (int n = 0; n < 400; n++) begin
      logic [13:0] c;
      int pick;
      pick = int'($urandom_range(0, 9));
      if (pick == 0)      c = 14'($urandom_range(0, 130));
      else if (pick == 1) c = 14'($urandom_range(16250, 16383));
      else                c = 14'($urandom);
      step(1'($urandom_range(0, 3) != 0), c, 1'($urandom_range(0, 7) == 0),
           8'($urandom), 1'($urandom), 1'($urandom), "R5/R9");
    end
    repeat (LAT + 2) step(0, 14'd0, 0, 8'd0, 1, 0, "R10");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule